// File: doc/BRIEF.md
# Coprocessor Escape Dispatch and Trap Unit

This block sits on the processor side of a processor and math-coprocessor pair. It takes each coprocessor escape or WAIT instruction from the decoder and settles its fate in one decision. The instruction is either sent on to the coprocessor, dropped as a legacy no-op, or turned into a trap with a vector number. The decision takes into account several inputs: the task-switched and emulation bits of the machine status word, an error reported by the coprocessor on its dedicated line, the coprocessor busy line, and a bounds check of the memory operand against its segment limit.

The decoder holds `instr_valid` together with the instruction fields until the unit answers. The answer is a one-cycle pulse on exactly one of `issue`, `skip` or `trap_valid`. A trap carries its vector on `trap_vec`. When an escape is issued, the unit latches the address of its first prefix byte, the operand offset and, in real mode, the opcode. These values are kept for exception handlers.

Top module: `esc_dispatch`

## Requirements
- R1: An escape of class 0, 1 or 3 traps with vector 7 when `msw_ts` or `msw_em` is 1. A WAIT (class 2) traps with vector 7 only when `msw_ts` is 1. `msw_em` alone lets a WAIT complete.
- R2: When several trap causes hold, exactly one vector is reported. The order is 7 first, then 16, then 13, then 9.
- R3: A numeric escape (class 0) or a WAIT is held while `cop_busy` is 1. It is issued in the first decision after `cop_busy` falls, and no time limit applies.
- R4: A control escape (class 1) with `wait_prefix` at 0 is issued even while `cop_busy` is 1. With `wait_prefix` at 1 it waits like a numeric escape.
- R5: A cycle with `cop_error` at 1 leaves an error pending until a vector 16 trap is taken. Class 0, class 2 and wait-prefixed class 1 instructions check the pending error. A class 1 instruction without the prefix ignores it and leaves it pending.
- R6: For class 0 or 1 with `has_mem` at 1, an `opnd_off` above `seg_limit` traps with vector 13.
- R7: For class 0 or 1 with `has_mem` at 1, suppose the start lies within the limit. If the last operand word, at `opnd_off + 2*(opnd_words-1)` computed without wraparound, lies above `seg_limit`, the unit traps with vector 9. A WAIT performs neither segment check.
- R8: When a class 0 or 1 escape is issued, `saved_ip` takes `prefix_addr` and `saved_dp` takes `opnd_off`. A trap or a skip leaves both unchanged.
- R9: On such an issue, `saved_opcode` takes `opcode` when `prot_mode` is 0, and becomes 0 when `prot_mode` is 1.
- R10: A legacy enable/disable escape (class 3) without a vector 7 cause gives a `skip` pulse and no `issue`. It leaves the saved registers and any pending error unchanged.
- R11: Each instruction gets exactly one one-cycle pulse on `issue`, `skip` or `trap_valid`, one cycle after its decision edge. A new decision is only made after that pulse, and `issue` stays low while a trap is signalled.
- R12: After reset all pulses are low and `trap_vec`, `saved_ip`, `saved_dp` and `saved_opcode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction presented, held until answered |
| instr_class | input | 2 | 0 numeric escape, 1 control escape, 2 WAIT, 3 legacy no-op escape |
| wait_prefix | input | 1 | Control escape preceded by a WAIT |
| prot_mode | input | 1 | Protected mode active |
| opcode | input | OPW | Escape opcode bits |
| prefix_addr | input | AW | Address of first prefix byte |
| msw_ts | input | 1 | Task-switched bit |
| msw_em | input | 1 | Emulation bit |
| cop_busy | input | 1 | Coprocessor busy |
| cop_error | input | 1 | Coprocessor error line |
| has_mem | input | 1 | Instruction has a memory operand |
| opnd_off | input | OW | Operand start offset |
| opnd_words | input | WW | Operand length in 16-bit words |
| seg_limit | input | OW | Segment limit, last valid offset |
| issue | output | 1 | Instruction issued (pulse) |
| skip | output | 1 | Legacy no-op retired (pulse) |
| trap_valid | output | 1 | Trap raised (pulse) |
| trap_vec | output | 8 | Trap vector number |
| saved_ip | output | AW | Latched instruction address |
| saved_dp | output | OW | Latched operand offset |
| saved_opcode | output | OPW | Latched opcode, 0 in protected mode |

## Verification
The bench targets the vector 9 case in which the last word lands past a limit of all ones. A design that lets the offset sum wrap would issue that instruction silently. It drives a WAIT with only the emulation bit set and a WAIT whose operand fields are out of range, so a unit that trapped on either would fail. It also checks that an error stays pending across a no-prefix control escape and across a legacy no-op. A design that cleared the error there would issue the later numeric escape instead of trapping with vector 16. The busy tests count the exact cycle of issue after a stall, and they confirm that a control escape without the prefix goes through while busy is held high.

// File: rtl/esc_dispatch.sv
module esc_dispatch #(
  parameter int AW  = 20,
  parameter int OW  = 16,
  parameter int WW  = 4,
  parameter int OPW = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           instr_valid,
  input  logic [1:0]     instr_class,
  input  logic           wait_prefix,
  input  logic           prot_mode,
  input  logic [OPW-1:0] opcode,
  input  logic [AW-1:0]  prefix_addr,
  input  logic           msw_ts,
  input  logic           msw_em,
  input  logic           cop_busy,
  input  logic           cop_error,
  input  logic           has_mem,
  input  logic [OW-1:0]  opnd_off,
  input  logic [WW-1:0]  opnd_words,
  input  logic [OW-1:0]  seg_limit,
  output logic           issue,
  output logic           skip,
  output logic           trap_valid,
  output logic [7:0]     trap_vec,
  output logic [AW-1:0]  saved_ip,
  output logic [OW-1:0]  saved_dp,
  output logic [OPW-1:0] saved_opcode
);
  localparam logic [1:0] C_NUM = 2'd0, C_CTL = 2'd1, C_WAIT = 2'd2, C_NOP = 2'd3;
  localparam int EW = OW + WW + 2;

  logic err_pend;
  logic accept, is_esc, is_mem_esc, synced, t7, t16, t13, t9;
  logic [WW-1:0] wm1;
  logic [EW-1:0] last_off;

  assign accept     = instr_valid & ~issue & ~skip & ~trap_valid;
  assign is_esc     = instr_class != C_WAIT;
  assign is_mem_esc = instr_class == C_NUM || instr_class == C_CTL;
  assign synced     = instr_class == C_NUM || instr_class == C_WAIT ||
                      (instr_class == C_CTL && wait_prefix);
  assign t7         = is_esc ? (msw_ts | msw_em) : msw_ts;
  assign t16        = synced & (err_pend | cop_error);
  assign wm1        = (opnd_words == '0) ? '0 : opnd_words - 1'b1;
  assign last_off   = EW'(opnd_off) + (EW'(wm1) << 1);
  assign t13        = is_mem_esc & has_mem & (opnd_off > seg_limit);
  assign t9         = is_mem_esc & has_mem & ~(opnd_off > seg_limit) &
                      (last_off > EW'(seg_limit));

  logic       trap_n, issue_n, skip_n;
  logic [7:0] vec_n;

  always_comb begin
    trap_n  = 1'b0;
    issue_n = 1'b0;
    skip_n  = 1'b0;
    vec_n   = 8'd0;
    if (accept) begin
      if (t7) begin
        trap_n = 1'b1; vec_n = 8'd7;
      end else if (instr_class == C_NOP) begin
        skip_n = 1'b1;
      end else if (t16) begin
        trap_n = 1'b1; vec_n = 8'd16;
      end else if (t13) begin
        trap_n = 1'b1; vec_n = 8'd13;
      end else if (t9) begin
        trap_n = 1'b1; vec_n = 8'd9;
      end else if (!(synced && cop_busy)) begin
        issue_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue        <= 1'b0;
      skip         <= 1'b0;
      trap_valid   <= 1'b0;
      trap_vec     <= 8'd0;
      err_pend     <= 1'b0;
      saved_ip     <= '0;
      saved_dp     <= '0;
      saved_opcode <= '0;
    end else begin
      issue      <= issue_n;
      skip       <= skip_n;
      trap_valid <= trap_n;
      trap_vec   <= vec_n;
      err_pend   <= (err_pend & ~(trap_n && vec_n == 8'd16)) | cop_error;
      if (issue_n && is_mem_esc) begin
        saved_ip     <= prefix_addr;
        saved_dp     <= opnd_off;
        saved_opcode <= prot_mode ? '0 : opcode;
      end
    end
  end
endmodule

module esc_dispatch_chk #(
  parameter int AW  = 20,
  parameter int OW  = 16,
  parameter int WW  = 4,
  parameter int OPW = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           instr_valid,
  input logic [1:0]     instr_class,
  input logic           prot_mode,
  input logic [AW-1:0]  prefix_addr,
  input logic           msw_ts,
  input logic           msw_em,
  input logic           cop_busy,
  input logic [OW-1:0]  opnd_off,
  input logic [OW-1:0]  seg_limit,
  input logic           issue,
  input logic           skip,
  input logic           trap_valid,
  input logic [7:0]     trap_vec,
  input logic [AW-1:0]  saved_ip,
  input logic [OPW-1:0] saved_opcode
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue, skip, trap_valid}));

  // R11
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue || skip || trap_valid) |=> !(issue || skip || trap_valid));

  // R1
  esc_trap7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(instr_valid && !issue && !skip && !trap_valid &&
                      instr_class != 2'd2 && (msw_ts || msw_em)))
    |-> (trap_valid && trap_vec == 8'd7));

  // R2
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_vec == 8'd7 || trap_vec == 8'd16 ||
                    trap_vec == 8'd13 || trap_vec == 8'd9));

  // R3
  busy_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && issue && $past(instr_class) == 2'd0) |-> $past(!cop_busy));

  // R6
  seg13_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_vec == 8'd13) |-> (past_ok && $past(opnd_off > seg_limit)));

  // R8
  saved_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && issue && $past(instr_class) != 2'd2) |-> saved_ip == $past(prefix_addr));

  // R9
  prot_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && issue && $past(instr_class) != 2'd2 && $past(prot_mode))
    |-> saved_opcode == '0);
endmodule

bind esc_dispatch esc_dispatch_chk #(.AW(AW), .OW(OW), .WW(WW), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_class(instr_class),
  .prot_mode(prot_mode), .prefix_addr(prefix_addr), .msw_ts(msw_ts), .msw_em(msw_em),
  .cop_busy(cop_busy), .opnd_off(opnd_off), .seg_limit(seg_limit), .issue(issue),
  .skip(skip), .trap_valid(trap_valid), .trap_vec(trap_vec), .saved_ip(saved_ip),
  .saved_opcode(saved_opcode));

// File: tb/esc_dispatch_bench.sv
`timescale 1ns/1ps
module esc_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [1:0]  instr_class = 2'd0;
  logic        wait_prefix = 1'b0, prot_mode = 1'b0;
  logic [10:0] opcode = '0;
  logic [19:0] prefix_addr = '0;
  logic        msw_ts = 1'b0, msw_em = 1'b0, cop_busy = 1'b0, cop_error = 1'b0;
  logic        has_mem = 1'b0;
  logic [15:0] opnd_off = '0, seg_limit = '0;
  logic [3:0]  opnd_words = 4'd1;
  logic        issue, skip, trap_valid;
  logic [7:0]  trap_vec;
  logic [19:0] saved_ip;
  logic [15:0] saved_dp;
  logic [10:0] saved_opcode;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  esc_dispatch u_esc_dispatch (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_class(instr_class),
    .wait_prefix(wait_prefix), .prot_mode(prot_mode), .opcode(opcode),
    .prefix_addr(prefix_addr), .msw_ts(msw_ts), .msw_em(msw_em), .cop_busy(cop_busy),
    .cop_error(cop_error), .has_mem(has_mem), .opnd_off(opnd_off),
    .opnd_words(opnd_words), .seg_limit(seg_limit), .issue(issue), .skip(skip),
    .trap_valid(trap_valid), .trap_vec(trap_vec), .saved_ip(saved_ip),
    .saved_dp(saved_dp), .saved_opcode(saved_opcode));

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  cls;
    logic        wp, ts, em, mem;
    logic [15:0] off;
    logic [3:0]  words;
    logic [15:0] lim;
    logic [1:0]  kind;
    logic [7:0]  vec;
  } vec_t;

  // kind: 0 issue, 1 trap, 2 skip
  localparam int N = 15;
  localparam vec_t TBL [N] = '{
    '{4'd1,  2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1, 16'h0000, 2'd1, 8'd7},  // R1
    '{4'd1,  2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 4'd1, 16'h0000, 2'd1, 8'd7},  // R1
    '{4'd1,  2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 4'd1, 16'h0000, 2'd0, 8'd0},  // R1
    '{4'd1,  2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1, 16'h0000, 2'd1, 8'd7},  // R1
    '{4'd1,  2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 4'd1, 16'h0000, 2'd1, 8'd7},  // R1
    '{4'd6,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0100, 4'd1, 16'h00FF, 2'd1, 8'd13}, // R6
    '{4'd7,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00F0, 4'd4, 16'h00F5, 2'd1, 8'd9},  // R7
    '{4'd7,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h00F0, 4'd4, 16'h00F6, 2'd0, 8'd0},  // R7
    '{4'd7,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFE, 4'd2, 16'hFFFF, 2'd1, 8'd9},  // R7
    '{4'd6,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0200, 4'd1, 16'h0010, 2'd0, 8'd0},  // R6
    '{4'd7,  2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0200, 4'd4, 16'h0010, 2'd0, 8'd0},  // R7
    '{4'd10, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd1, 16'h0000, 2'd2, 8'd0},  // R10
    '{4'd1,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd1, 16'h0000, 2'd1, 8'd7},  // R1
    '{4'd6,  2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0040, 4'd1, 16'h0040, 2'd0, 8'd0},  // R6
    '{4'd2,  2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0300, 4'd1, 16'h0010, 2'd1, 8'd7}   // R2
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic wp, input logic ts, input logic em,
                       input logic mem, input logic [15:0] off, input logic [3:0] w,
                       input logic [15:0] lim);
    instr_class = c; wait_prefix = wp; msw_ts = ts; msw_em = em;
    has_mem = mem; opnd_off = off; opnd_words = w; seg_limit = lim;
    instr_valid = 1'b1;
  endtask

  // kind 0 issue, 1 trap, 2 skip, 3 none within limit
  task automatic await(output int kind, output int vec, output int cyc);
    kind = 3; vec = 0; cyc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cyc++;
      if (issue || skip || trap_valid) begin
        kind = issue ? 0 : (trap_valid ? 1 : 2);
        vec = trap_vec;
        break;
      end
    end
    instr_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int k, v, c;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!issue && !skip && !trap_valid && trap_vec == 0 && saved_ip == 0 &&
        saved_dp == 0 && saved_opcode == 0, "R12 reset", {issue, skip, trap_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i].cls, TBL[i].wp, TBL[i].ts, TBL[i].em, TBL[i].mem,
            TBL[i].off, TBL[i].words, TBL[i].lim);
      await(k, v, c);
      chk(k == int'(TBL[i].kind) && (k != 1 || v == int'(TBL[i].vec)) && c == 1,
          $sformatf("R%0d vec row %0d kind/vec/cyc", TBL[i].req, i),
          k * 1000 + v * 10 + c, int'(TBL[i].kind) * 1000 + int'(TBL[i].vec) * 10 + 1);
    end

    // R3 numeric escape stalls on busy, issues one cycle after release
    cop_busy = 1'b1;
    drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'd1, 16'h0);
    k = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (issue || trap_valid || skip) k++;
    end
    chk(k == 0, "R3 stall while busy", k, 0);
    cop_busy = 1'b0;
    await(k, v, c);
    chk(k == 0 && c == 1, "R3 issue after busy drops", k * 10 + c, 1);

    // R4 control escape without prefix ignores busy
    cop_busy = 1'b1;
    drive(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'd1, 16'h0);
    await(k, v, c);
    chk(k == 0 && c == 1, "R4 control no prefix while busy", k * 10 + c, 1);
    // R4 with prefix it waits
    drive(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 4'd1, 16'h0);
    repeat (4) @(negedge clk);
    chk(!issue, "R4 prefixed control waits", issue, 0);
    cop_busy = 1'b0;
    await(k, v, c);
    chk(k == 0, "R4 prefixed control issues after busy", k, 0);

    // R5 error pending: ignored by unprefixed control, trapped by numeric
    cop_error = 1'b1; @(negedge clk); cop_error = 1'b0;
    drive(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'd1, 16'h0);
    await(k, v, c);
    chk(k == 0, "R5 unprefixed control ignores error", k, 0);
    drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0100, 4'd1, 16'h0010);
    await(k, v, c);
    chk(k == 1 && v == 16, "R5 numeric traps 16 over 13 (R2)", v, 16);
    drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'd1, 16'h0);
    await(k, v, c);
    chk(k == 0, "R5 error cleared after trap", k, 0);

    // R2 vector 7 beats pending error
    cop_error = 1'b1; @(negedge clk); cop_error = 1'b0;
    drive(2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 4'd1, 16'h0);
    await(k, v, c);
    chk(k == 1 && v == 7, "R2 vector 7 over error", v, 7);
    // R10 no-op keeps error pending
    drive(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'd1, 16'h0);
    await(k, v, c);
    chk(k == 2, "R10 no-op skip with error pending", k, 2);
    drive(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'd1, 16'h0);
    await(k, v, c);
    chk(k == 1 && v == 16, "R10 error survives no-op, WAIT traps 16", v, 16);

    // R8 / R9 saved pointers
    prefix_addr = 20'h1A2B3; opcode = 11'h5C1; prot_mode = 1'b0;
    drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0042, 4'd2, 16'h0100);
    await(k, v, c);
    chk(saved_ip == 20'h1A2B3 && saved_dp == 16'h0042, "R8 saved ip/dp",
        int'(saved_ip), 'h1A2B3);
    chk(saved_opcode == 11'h5C1, "R9 real mode opcode", saved_opcode, 'h5C1);
    prefix_addr = 20'h0F00D; opcode = 11'h2AA; prot_mode = 1'b1;
    drive(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0077, 4'd1, 16'h0);
    await(k, v, c);
    chk(saved_opcode == 0 && saved_ip == 20'h0F00D, "R9 protected mode opcode zero",
        saved_opcode, 0);
    prefix_addr = 20'h33333; prot_mode = 1'b0;
    drive(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0999, 4'd1, 16'h0);
    await(k, v, c);
    chk(saved_ip == 20'h0F00D && saved_dp == 16'h0077, "R10 no-op keeps saved",
        int'(saved_ip), 'h0F00D);
    drive(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0555, 4'd1, 16'h0);
    await(k, v, c);
    chk(saved_ip == 20'h0F00D && saved_dp == 16'h0077, "R8 trap keeps saved",
        int'(saved_dp), 'h77);

    // R11 held valid gives a single pulse then a fresh decision
    drive(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 4'd1, 16'h0);
    @(negedge clk);
    k = issue;
    @(negedge clk);
    chk(k == 1 && !issue, "R11 single pulse per decision", {k[0], issue}, 2);
    instr_valid = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule